// File: doc/BRIEF.md
# Byte Memory Interface Unit

This unit sits between a microcoded 8-bit datapath and a single byte-wide main memory that serves both instructions and data over a 16-bit address. It holds the two address byte registers, a write-data register, a memory-data register and the instruction register. Each clock cycle the microcode presents a 4-bit ALU destination code together with the byte on the ALU result bus. It also presents a 2-bit capture code that says which registers take the byte coming back from memory.

No separate request pin exists. An access begins as a side effect of loading the low address register: one destination code loads that register and starts a read, and another loads it and starts a write. The high address byte and, for a write, the store byte must be in place beforehand. Every access lasts exactly two cycles, and the unit shows these cycles on a busy output. In the first access cycle the memory enable is raised with the full address. In the second cycle a read's byte appears on the unit's memory bus output. That byte stays on the bus until the next read returns its data.

The memory side has fixed timing and accepts every enable, so there is no valid/ready pair and no back-pressure. The microprogram itself must respect the busy window. A start that arrives while an access is in flight is dropped and flagged.

Top module: `byte_mem_if`

## Requirements
- R1: After reset, every interface register (high address, low address, store byte, memory data, instruction), the memory bus output, busy and the error output read zero.
- R2: ALU destination code 10 loads the high address register and code 15 loads the store-byte register from the ALU bus. Any other code leaves both unchanged, and codes other than 11 and 13 also leave the low address register unchanged.
- R3: When idle, code 11 loads the low address register and starts a read. Busy is 1 for exactly the two following cycles. In the first of them the memory enable is 1, write enable is 0 and the address is {high, low}.
- R4: When idle, code 13 loads the low address register and starts a write. In the first busy cycle the memory enable and write enable are 1 and the write data equal the store-byte register, so the byte lands at {high, low}.
- R5: A read's returned byte appears on the memory bus output in the second busy cycle. It then holds there unchanged until a later read returns data; writes do not change it.
- R6: The 2-bit capture code applies in every cycle and draws from the memory bus output. 0 loads nothing, 1 loads the memory data register, 2 loads the memory data and low address registers, and 3 loads memory data, low address and instruction registers.
- R7: Code 11 or 13 arriving while busy is ignored. The low address register is not loaded by it, the access in flight keeps its two-cycle length, and the error output is 1 for the following cycle only.
- R8: A start in the first cycle after busy falls is accepted normally, so back-to-back accesses need no idle gap beyond the busy window.
- R9: If an accepted start and a capture code of 2 or 3 fall in the same cycle, the low address register takes the ALU bus byte. The other captured registers still load from the memory bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_dest | input | 4 | ALU destination code from the current microinstruction |
| alu_bus | input | 8 | ALU result byte |
| mem_dest | input | 2 | Capture code for the returned byte |
| mah_q | output | 8 | High address register |
| mal_q | output | 8 | Low address register |
| mw_q | output | 8 | Store-byte register |
| md_q | output | 8 | Memory data register |
| ir_q | output | 8 | Instruction register |
| mem_bus | output | 8 | Memory data bus toward the datapath |
| busy | output | 1 | Access in progress |
| access_err | output | 1 | One-cycle pulse: start dropped because busy |
| mem_en | output | 1 | Memory enable, first access cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after enable |

## Verification
The hardest cases to reach are the ones where a start command collides with other activity. One is a second start issued in the middle of an access. Another is a start in the very cycle after busy falls. A third is an accepted start in the same cycle as a capture code that also targets the low address register. Directed tasks drive exact cycle-by-cycle command sequences for each of these. The bench then checks the low address register, the error pulse, the length of the busy window and the captured bytes against a bench-side memory whose contents are a computed pattern.

// File: rtl/mif_pkg.sv
package mif_pkg;

  // ALU destination codes that this unit responds to
  localparam logic [3:0] DST_ADDR_HI  = 4'd10;
  localparam logic [3:0] DST_ADDR_RD  = 4'd11;
  localparam logic [3:0] DST_ADDR_WR  = 4'd13;
  localparam logic [3:0] DST_STORE    = 4'd15;

  // Capture selection for the returned byte
  typedef enum logic [1:0] {
    CAP_NONE   = 2'd0,
    CAP_MD     = 2'd1,
    CAP_MD_LO  = 2'd2,
    CAP_ALL    = 2'd3
  } cap_sel_e;

  // Decoded datapath command
  typedef struct packed {
    logic ld_hi;
    logic ld_store;
    logic start;
    logic wr;
  } dp_cmd_t;

endpackage

// File: rtl/mif_cmd_decode.sv
module mif_cmd_decode
  import mif_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output dp_cmd_t           cmd
);

  always_comb begin
    cmd          = '0;
    cmd.ld_hi    = (code == DST_ADDR_HI);
    cmd.ld_store = (code == DST_STORE);
    cmd.start    = (code == DST_ADDR_RD) || (code == DST_ADDR_WR);
    cmd.wr       = (code == DST_ADDR_WR);
  end

endmodule

// File: rtl/mif_access_seq.sv
module mif_access_seq #(
  parameter int ACCESS_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic start_wr,
  output logic start_ok,
  output logic busy,
  output logic first,
  output logic last,
  output logic op_wr,
  output logic err
);

  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign busy     = (cnt != '0);
  assign first    = (cnt == CNT_W'(1));
  assign last     = (cnt == CNT_W'(ACCESS_CYCLES));
  assign start_ok = start_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      op_wr <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= start_req && busy;
      if (start_ok) begin
        cnt   <= CNT_W'(1);
        op_wr <= start_wr;
      end else if (busy) begin
        cnt <= last ? '0 : cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/mif_addr_regs.sv
module mif_addr_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_store,
  input  logic              ld_lo,
  input  logic              cap_lo,
  input  logic [DATA_W-1:0] alu_bus,
  input  logic [DATA_W-1:0] cap_bus,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] store_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      store_q <= '0;
    end else begin
      if (ld_hi)    hi_q    <= alu_bus;
      if (ld_store) store_q <= alu_bus;
      // datapath load of the low byte wins over a memory capture
      if (ld_lo)       lo_q <= alu_bus;
      else if (cap_lo) lo_q <= cap_bus;
    end
  end

endmodule

// File: rtl/mif_capture.sv
module mif_capture
  import mif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              op_wr,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] bus_out,
  output logic              cap_lo,
  output logic [DATA_W-1:0] md_q,
  output logic [DATA_W-1:0] ir_q
);

  cap_sel_e          sel_e;
  logic              rd_valid;
  logic [DATA_W-1:0] hold_q;

  assign sel_e    = cap_sel_e'(sel);
  assign rd_valid = last && !op_wr;
  assign bus_out  = rd_valid ? rdata : hold_q;
  assign cap_lo   = (sel_e == CAP_MD_LO) || (sel_e == CAP_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      md_q   <= '0;
      ir_q   <= '0;
    end else begin
      if (rd_valid)          hold_q <= rdata;
      if (sel_e != CAP_NONE) md_q   <= bus_out;
      if (sel_e == CAP_ALL)  ir_q   <= bus_out;
    end
  end

endmodule

// File: rtl/byte_mem_if.sv
module byte_mem_if
  import mif_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CODE_W        = 4,
  parameter int ACCESS_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     alu_dest,
  input  logic [DATA_W-1:0]     alu_bus,
  input  logic [1:0]            mem_dest,
  output logic [DATA_W-1:0]     mah_q,
  output logic [DATA_W-1:0]     mal_q,
  output logic [DATA_W-1:0]     mw_q,
  output logic [DATA_W-1:0]     md_q,
  output logic [DATA_W-1:0]     ir_q,
  output logic [DATA_W-1:0]     mem_bus,
  output logic                  busy,
  output logic                  access_err,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata
);

  dp_cmd_t cmd;
  logic    start_ok;
  logic    first;
  logic    last;
  logic    op_wr;
  logic    cap_lo;

  mif_cmd_decode #(.CODE_W(CODE_W)) u_dec (
    .code (alu_dest),
    .cmd  (cmd)
  );

  mif_access_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (cmd.start),
    .start_wr  (cmd.wr),
    .start_ok  (start_ok),
    .busy      (busy),
    .first     (first),
    .last      (last),
    .op_wr     (op_wr),
    .err       (access_err)
  );

  mif_addr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_hi    (cmd.ld_hi),
    .ld_store (cmd.ld_store),
    .ld_lo    (start_ok),
    .cap_lo   (cap_lo),
    .alu_bus  (alu_bus),
    .cap_bus  (mem_bus),
    .hi_q     (mah_q),
    .lo_q     (mal_q),
    .store_q  (mw_q)
  );

  mif_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .last    (last),
    .op_wr   (op_wr),
    .rdata   (mem_rdata),
    .sel     (mem_dest),
    .bus_out (mem_bus),
    .cap_lo  (cap_lo),
    .md_q    (md_q),
    .ir_q    (ir_q)
  );

  assign mem_addr  = {mah_q, mal_q};
  assign mem_en    = first;
  assign mem_we    = first && op_wr;
  assign mem_wdata = mw_q;

endmodule

// File: rtl/byte_mem_if_chk.sv
module byte_mem_if_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] alu_dest,
  input logic [1:0]        mem_dest,
  input logic [DATA_W-1:0] mal_q,
  input logic [DATA_W-1:0] md_q,
  input logic [DATA_W-1:0] ir_q,
  input logic              busy,
  input logic              access_err,
  input logic              mem_en,
  input logic              mem_we
);

  logic start_cmd;
  assign start_cmd = (alu_dest == 4'd11) || (alu_dest == 4'd13);

  // R3: an idle start opens the busy window
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !busy) |=> busy);

  // R3: enable appears once, and the window continues one more cycle
  assert_en_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> (busy && !mem_en));

  assert_en_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);

  // R4: a write enable only follows a write start
  assert_we_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && $past(alu_dest == 4'd13)));

  // R7: error pulse only after a start seen while busy
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> ($past(busy) && $past(start_cmd)));

  // R7: dropped start does not touch the low address register
  assert_drop_keeps_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && busy && !mem_dest[1]) |=> (mal_q == $past(mal_q)));

  // R6: capture code 0 leaves memory data alone
  assert_md_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dest == 2'd0) |=> (md_q == $past(md_q)));

  // R6: instruction register only loads on code 3
  assert_ir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dest != 2'd3) |=> (ir_q == $past(ir_q)));

endmodule

bind byte_mem_if byte_mem_if_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/test_byte_mem_if.sv
module test_byte_mem_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_dest = '0;
  logic [7:0]  alu_bus = '0;
  logic [1:0]  mem_dest = '0;
  logic [7:0]  mah_q, mal_q, mw_q, md_q, ir_q, mem_bus, mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, access_err, mem_en, mem_we;
  logic [15:0] mem_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_mem_if i_byte_mem_if (
    .clk(clk), .rst_n(rst_n), .alu_dest(alu_dest), .alu_bus(alu_bus),
    .mem_dest(mem_dest), .mah_q(mah_q), .mal_q(mal_q), .mw_q(mw_q),
    .md_q(md_q), .ir_q(ir_q), .mem_bus(mem_bus), .busy(busy),
    .access_err(access_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // simple memory: 1024 bytes indexed by the low address bits
  logic [7:0] mem [1024];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) + 11);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, return at the following negedge
  task automatic step(logic [3:0] d, logic [7:0] b, logic [1:0] m);
    alu_dest = d; alu_bus = b; mem_dest = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(4'd0, 8'd0, 2'd0);
  endtask

  task automatic t_reset;
    chk("R1 mah", mah_q, 0); chk("R1 mal", mal_q, 0); chk("R1 mw", mw_q, 0);
    chk("R1 md", md_q, 0);   chk("R1 ir", ir_q, 0);   chk("R1 bus", mem_bus, 0);
    chk("R1 busy", busy, 0); chk("R1 err", access_err, 0);
  endtask

  task automatic t_regs;
    step(4'd10, 8'h12, 2'd0);
    step(4'd15, 8'hA5, 2'd0);
    step(4'd1,  8'h77, 2'd0);
    step(4'd12, 8'h66, 2'd0);
    chk("R2 mah", mah_q, 8'h12);
    chk("R2 mw", mw_q, 8'hA5);
    chk("R2 mal untouched", mal_q, 8'h00);
    chk("R2 no access", busy, 0);
  endtask

  task automatic t_read_all;
    step(4'd10, 8'h02, 2'd0);
    step(4'd11, 8'h34, 2'd0);
    chk("R3 busy c1", busy, 1);
    chk("R3 en c1", mem_en, 1);
    chk("R3 we c1", mem_we, 0);
    chk("R3 addr", mem_addr, 16'h0234);
    step(4'd0, 8'h00, 2'd0);
    chk("R3 busy c2", busy, 1);
    chk("R3 en c2", mem_en, 0);
    chk("R5 bus valid", mem_bus, pat(16'h234));
    step(4'd0, 8'h00, 2'd3);
    chk("R3 busy end", busy, 0);
    chk("R6 code3 md", md_q, pat(16'h234));
    chk("R6 code3 ir", ir_q, pat(16'h234));
    chk("R6 code3 mal", mal_q, pat(16'h234));
    idle(3);
    chk("R5 bus held", mem_bus, pat(16'h234));
  endtask

  task automatic t_read_codes;
    logic [7:0] ir_before;
    ir_before = ir_q;
    step(4'd10, 8'h01, 2'd0);
    step(4'd11, 8'h05, 2'd0);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd1);
    chk("R6 code1 md", md_q, pat(16'h105));
    chk("R6 code1 mal kept", mal_q, 8'h05);
    chk("R6 code1 ir kept", ir_q, ir_before);
    step(4'd11, 8'h09, 2'd0);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd0);
    chk("R6 code0 md kept", md_q, pat(16'h105));
    chk("R5 new data on bus", mem_bus, pat(16'h109));
    step(4'd0, 8'h00, 2'd2);
    chk("R6 code2 md", md_q, pat(16'h109));
    chk("R6 code2 mal", mal_q, pat(16'h109));
    chk("R6 code2 ir kept", ir_q, ir_before);
  endtask

  task automatic t_write;
    logic [7:0] bus_before;
    bus_before = mem_bus;
    step(4'd10, 8'h01, 2'd0);
    step(4'd15, 8'h5C, 2'd0);
    step(4'd13, 8'h80, 2'd0);
    chk("R4 en", mem_en, 1);
    chk("R4 we", mem_we, 1);
    chk("R4 wdata", mem_wdata, 8'h5C);
    chk("R4 addr", mem_addr, 16'h0180);
    step(4'd0, 8'h00, 2'd0);
    chk("R4 busy c2", busy, 1);
    chk("R5 write leaves bus", mem_bus, bus_before);
    step(4'd0, 8'h00, 2'd0);
    chk("R4 done", busy, 0);
    step(4'd11, 8'h80, 2'd0);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd1);
    chk("R4 readback", md_q, 8'h5C);
  endtask

  task automatic t_overlap;
    step(4'd10, 8'h00, 2'd0);
    step(4'd11, 8'h10, 2'd0);
    step(4'd11, 8'h55, 2'd0);
    chk("R7 err pulse", access_err, 1);
    chk("R7 mal kept", mal_q, 8'h10);
    chk("R7 still busy", busy, 1);
    step(4'd13, 8'h66, 2'd1);
    chk("R7 window not extended", busy, 0);
    chk("R7 err again", access_err, 1);
    chk("R7 data of first", md_q, pat(16'h010));
    chk("R7 mal kept 2", mal_q, 8'h10);
    step(4'd0, 8'h00, 2'd0);
    chk("R7 err one cycle", access_err, 0);
    chk("R7 no write", mem_we, 0);
  endtask

  task automatic t_b2b;
    step(4'd10, 8'h03, 2'd0);
    step(4'd11, 8'h21, 2'd0);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd1);
    chk("R8 first data", md_q, pat(16'h321));
    step(4'd11, 8'h22, 2'd0);
    chk("R8 accepted", busy, 1);
    chk("R8 no err", access_err, 0);
    chk("R8 addr", mem_addr, 16'h0322);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd1);
    chk("R8 second data", md_q, pat(16'h322));
  endtask

  task automatic t_prio;
    logic [7:0] held;
    held = mem_bus;
    step(4'd11, 8'h44, 2'd3);
    chk("R9 mal from alu", mal_q, 8'h44);
    chk("R9 md from bus", md_q, held);
    chk("R9 ir from bus", ir_q, held);
    chk("R9 started", busy, 1);
    step(4'd0, 8'h00, 2'd0);
    step(4'd0, 8'h00, 2'd1);
    chk("R9 data", md_q, pat(16'h344));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_read_all();
    t_read_codes();
    t_write();
    t_overlap();
    t_b2b();
    t_prio();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule